// File: doc/BRIEF.md
# Duty-Cycled Receiver Wake Timer

This block sequences a receiver that wakes periodically to listen and sleeps otherwise. A host talks to it over one shared data line, which an external pull-up holds high. Once duty-cycle mode is enabled, a rising edge on the line starts a wake cycle. The cycle runs three phases in turn: a host-wake phase, an RF-settle phase, and then a programmable on phase. The receiver-enable output is high for all three. If the host pulls the line low at any point in that window, the block holds the receiver on for as long as the line stays low. If the host does not answer, the receiver powers down for an off period and the cycle then starts again by itself.

Software writes the on time as two bytes over a write-only register bus. It also writes a configuration byte that holds the enable bit and a two-bit time-base select. The base unit is 120 µs, and its length in clock cycles comes from the clock-frequency parameter. The wake, settle and off lengths are parameters, counted in base units. The line is brought in through a two-flop synchroniser. The block never drives the line.

Top module: `rx_duty_timer`

## Requirements
- R1: After reset, `phase` reads 0 (idle) and `rx_en` is low.
- R2: The on-time upper byte is written at address 0x0B and the lower byte at 0x0C. The configuration byte is at 0x0D, with bit 0 as enable and bits 2:1 as time-base select. The on-time value resets to zero, so a cycle run before any on-time write has no on phase.
- R3: `phase` encodes idle=0, off=1, wake=2, settle=3, on=4, hold=5. `rx_en` is high exactly in phases 2 to 5.
- R4: With enable set, a rising edge of the synchronised line in idle, off or hold enters the wake phase.
- R5: Wake lasts WAKE_T base units and settle lasts SETTLE_T base units, and they always run in that order. One base unit is (CLK_HZ/25000)*3 clock cycles.
- R6: The on phase follows settle and lasts on-value times the time base. Select 0, 1, 2 and 3 give 1, 4, 16 and 64 base units per count.
- R7: An on value of zero makes settle go straight to off.
- R8: A low line during wake, settle or on enters hold. Hold keeps `rx_en` high for as long as the line stays low, even past the programmed on time.
- R9: With no acknowledgement, the end of the on phase enters off. After OFF_T base units in off, the wake phase starts again.
- R10: A configuration write that clears enable puts the block in idle with `rx_en` low on the next cycle.
- R11: A low line in idle or off changes nothing. Only its return high has an effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| line_in | input | 1 | Sampled level of the shared pulled-up line |
| rx_en | output | 1 | Receiver enable |
| phase | output | 3 | Current sequencing phase |

## Verification
Unanswered cycles are run with an on value of zero, with a small value at each of the four time-base selects, and with only the upper byte set. Each phase length is compared to the cycle, which tells the select scaling and byte placement apart. Acknowledgements are given at three points: in the on phase, in the wake phase, and as a low pulse during off. These show that only the wake, settle and on phases react to a low line, while off waits for the rising edge. Clearing enable while in wake and while in on checks the immediate return to idle.

// File: rtl/rx_duty_timer.sv
module rx_duty_timer #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int WAKE_T   = 8,
  parameter int SETTLE_T = 4,
  parameter int OFF_T    = 16,
  parameter logic [7:0] ADDR_HI  = 8'h0B,
  parameter logic [7:0] ADDR_LO  = 8'h0C,
  parameter logic [7:0] ADDR_CFG = 8'h0D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       line_in,
  output logic       rx_en,
  output logic [2:0] phase
);
  localparam int BASE_CYC = (CLK_HZ / 25000) * 3;
  localparam int CW = $clog2(BASE_CYC * 64) + 1;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_OFF = 3'd1, S_WAKE = 3'd2,
    S_SETTLE = 3'd3, S_ON = 3'd4, S_HOLD = 3'd5
  } st_t;

  st_t         st, nxt;
  logic [7:0]  on_hi, on_lo;
  logic        en;
  logic [1:0]  sel;
  logic        line_m, line_s, line_q;
  logic [CW-1:0] pcnt, lim;
  logic [15:0] dcnt, dur;

  wire [15:0] on_val = {on_hi, on_lo};
  wire cfg_wr = wr_en && (wr_addr == ADDR_CFG);
  wire en_nx  = cfg_wr ? wr_data[0] : en;
  wire rise   = line_s && !line_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      on_hi <= '0;
      on_lo <= '0;
      en    <= 1'b0;
      sel   <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_HI) on_hi <= wr_data;
      if (wr_addr == ADDR_LO) on_lo <= wr_data;
      if (cfg_wr) begin
        en  <= wr_data[0];
        sel <= wr_data[2:1];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {line_m, line_s, line_q} <= 3'b111;
    else        {line_m, line_s, line_q} <= {line_in, line_m, line_s};

  assign lim = (st == S_ON) ? (CW'(BASE_CYC) << {sel, 1'b0}) : CW'(BASE_CYC);
  wire tick = (pcnt >= lim - 1'b1);
  wire last = tick && (dcnt == 16'd1);

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE:   if (rise) nxt = S_WAKE;
      S_OFF:    if (rise || last) nxt = S_WAKE;
      S_WAKE:   if (!line_s) nxt = S_HOLD;
                else if (last) nxt = S_SETTLE;
      S_SETTLE: if (!line_s) nxt = S_HOLD;
                else if (last) nxt = (on_val == 16'd0) ? S_OFF : S_ON;
      S_ON:     if (!line_s) nxt = S_HOLD;
                else if (last) nxt = S_OFF;
      S_HOLD:   if (rise) nxt = S_WAKE;
      default:  nxt = S_IDLE;
    endcase
    if (!en_nx) nxt = S_IDLE;
  end

  always_comb
    case (nxt)
      S_WAKE:   dur = 16'(WAKE_T);
      S_SETTLE: dur = 16'(SETTLE_T);
      S_ON:     dur = on_val;
      S_OFF:    dur = 16'(OFF_T);
      default:  dur = '0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st   <= S_IDLE;
      pcnt <= '0;
      dcnt <= '0;
    end else begin
      st <= nxt;
      if (nxt != st) begin
        pcnt <= '0;
        dcnt <= dur;
      end else if (tick) begin
        pcnt <= '0;
        dcnt <= dcnt - 16'd1;
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end

  assign rx_en = (st == S_WAKE) || (st == S_SETTLE) || (st == S_ON) || (st == S_HOLD);
  assign phase = st;
endmodule

// File: rtl/rx_duty_timer_chk.sv
module rx_duty_timer_chk #(
  parameter logic [7:0] ADDR_CFG = 8'h0D
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [2:0] phase,
  input logic       rx_en,
  input logic       line_s,
  input logic       line_q,
  input logic       en
);
  wire cfg_any = wr_en && (wr_addr == ADDR_CFG);
  wire cfg_off = cfg_any && !wr_data[0];
  wire window  = (phase == 3'd2) || (phase == 3'd3) || (phase == 3'd4);

  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= 3'd5); // R3

  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_off |=> (phase == 3'd0) && !rx_en); // R10

  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    window && !line_s && en && !cfg_any |=> phase == 3'd5); // R8

  AST_HOLD_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd5) && !line_s && en && !cfg_any |=> (phase == 3'd5) && rx_en); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0) && !(line_s && !line_q) |=> phase == 3'd0); // R11

  AST_SETTLE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd3) && ($past(phase) != 3'd3) |-> $past(phase) == 3'd2); // R5

  AST_ON_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd4) && ($past(phase) != 3'd4) |-> $past(phase) == 3'd3); // R6
endmodule

bind rx_duty_timer rx_duty_timer_chk #(.ADDR_CFG(ADDR_CFG)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .phase(phase), .rx_en(rx_en), .line_s(line_s), .line_q(line_q), .en(en)
);

// File: tb/test_rx_duty_timer.sv
module test_rx_duty_timer;
  localparam int BC = 12;
  localparam int WT = 3, ST = 2, OT = 5;
  localparam int ANY = 1 << 30;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, line_in = 1'b1;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic rx_en;
  logic [2:0] phase;

  rx_duty_timer #(.CLK_HZ(100_000), .WAKE_T(WT), .SETTLE_T(ST), .OFF_T(OT)) i_rx_duty_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .line_in(line_in), .rx_en(rx_en), .phase(phase));

  always #10 clk = ~clk;

  typedef struct { int ph; int lo; int hi; string tag; } exp_t;
  exp_t q[$];
  int total = 0, bad = 0, cyc = 0, prev_cyc = 0;
  logic [2:0] prev = 3'd0;
  bit done = 0;

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic push(int ph, int lo, int hi, string tag);
    exp_t e;
    e.ph = ph; e.lo = lo; e.hi = hi; e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && phase !== prev) begin
      if (q.size() == 0) chk(0, "R3", "unexpected phase", int'(phase), int'(prev));
      else begin
        exp_t e;
        int d;
        e = q.pop_front();
        d = cyc - prev_cyc;
        chk(phase == 3'(e.ph), e.tag, "phase", int'(phase), e.ph);
        chk(d >= e.lo && d <= e.hi, e.tag, "cycles in previous phase", d, e.lo);
        chk(rx_en == (phase >= 3'd2 && phase <= 3'd5), "R3", "rx_en vs phase", int'(rx_en), int'(phase >= 3'd2));
      end
      prev = phase;
      prev_cyc = cyc;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    idle(1);
  endtask

  task automatic kick();
    line_in = 1'b0;
    idle(3);
    push(2, 0, ANY, "R4");
    line_in = 1'b1;
  endtask

  task automatic stop_en();
    push(0, 0, ANY, "R10");
    wr(8'h0D, 8'h00);
    drain();
    chk(rx_en == 1'b0 && phase == 3'd0, "R10", "idle after disable", int'(phase), 0);
  endtask

  initial begin
    idle(5);
    chk(phase == 3'd0 && rx_en == 1'b0, "R1", "reset phase", int'(phase), 0);
    rst_n = 1'b1;
    idle(2);
    chk(phase == 3'd0 && rx_en == 1'b0, "R1", "phase after reset", int'(phase), 0);

    // unwritten on time -> no on phase (R2, R7), automatic restart (R9)
    wr(8'h0D, 8'h01);
    idle(3);
    chk(phase == 3'd0, "R4", "enable alone does not start", int'(phase), 0);
    line_in = 1'b0;
    idle(4);
    chk(phase == 3'd0, "R11", "low line in idle", int'(phase), 0);
    push(2, 0, ANY, "R4");
    line_in = 1'b1;
    push(3, WT*BC, WT*BC, "R5");
    push(1, ST*BC, ST*BC, "R7");
    push(2, OT*BC, OT*BC, "R9");
    drain();
    stop_en();

    // select 01, on=3
    wr(8'h0B, 8'h00);
    wr(8'h0C, 8'h03);
    wr(8'h0D, 8'h03);
    kick();
    push(3, WT*BC, WT*BC, "R5");
    push(4, ST*BC, ST*BC, "R6");
    push(1, 3*4*BC, 3*4*BC, "R6");
    push(2, OT*BC, OT*BC, "R9");
    drain();
    stop_en();

    // acknowledge in on phase, hold past on time
    wr(8'h0C, 8'h05);
    wr(8'h0D, 8'h01);
    kick();
    push(3, WT*BC, WT*BC, "R5");
    push(4, ST*BC, ST*BC, "R6");
    drain();
    idle(10);
    push(5, 0, ANY, "R8");
    line_in = 1'b0;
    idle(300);
    chk(phase == 3'd5 && rx_en == 1'b1, "R8", "hold beyond on time", int'(phase), 5);
    push(2, 0, ANY, "R4");
    line_in = 1'b1;
    push(3, WT*BC, WT*BC, "R5");
    drain();
    stop_en();

    // select 11, on=1; rise in off; ack in wake; disable in on
    wr(8'h0C, 8'h01);
    wr(8'h0D, 8'h07);
    kick();
    push(3, WT*BC, WT*BC, "R5");
    push(4, ST*BC, ST*BC, "R6");
    push(1, 64*BC, 64*BC, "R6");
    drain();
    idle(5);
    line_in = 1'b0;
    idle(4);
    chk(phase == 3'd1, "R11", "low line in off", int'(phase), 1);
    push(2, 1, OT*BC - 1, "R4");
    line_in = 1'b1;
    drain();
    idle(5);
    push(5, 0, ANY, "R8");
    line_in = 1'b0;
    idle(6);
    push(2, 0, ANY, "R4");
    line_in = 1'b1;
    push(3, WT*BC, WT*BC, "R5");
    push(4, ST*BC, ST*BC, "R6");
    drain();
    idle(20);
    stop_en();

    // upper byte only, select 10: on = 256 counts of 16 base units
    wr(8'h0B, 8'h01);
    wr(8'h0C, 8'h00);
    wr(8'h0D, 8'h05);
    kick();
    push(3, WT*BC, WT*BC, "R5");
    push(4, ST*BC, ST*BC, "R6");
    push(1, 256*16*BC, 256*16*BC, "R2");
    drain();
    stop_en();

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL R3 watchdog actual=%0d expected=%0d", q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule